// File: doc/BRIEF.md
# I2C Bus-Speed Divider Code Search

This block picks the prescaler setting for an I2C controller. Given the frequency of the clock feeding the controller, the bus speed wanted and the digital input filter setting, it computes the integer ratio between the two frequencies. It then searches a fixed two-level grid of prescaler settings for the smallest resulting divisor that still exceeds that ratio. Because the divisor is always above the ratio, the bus never runs faster than requested.

The search runs one candidate per clock. The ratio and the resulting bus speed come from one shared shift-and-subtract divider. A single `start` pulse launches a search. `busy` stays high for the whole search, and a one-cycle `done` pulse marks the cycle in which the packed 8-bit divider code, the chosen divisor and the bus speed it gives are all valid. These outputs then hold until the next search.

Top module: `clkdiv_search`

## Requirements
- R1: The ratio is floor(src_hz / req_hz), clamped to 65535. A zero req_hz gives the clamped value 65535.
- R2: The outer setting ga starts at 4 with a = 10, and each outer step adds 1 to ga and 2 to a. The inner setting gb runs 0 to 7 with b = 16 << gb. A candidate divisor is b * (a + 2 * floor(3 * filt / b)).
- R3: Once the a = 24 row has been evaluated, the next row tried is a = 30 (ga = 12) and it is the final row. a = 26 and a = 28 are never tried.
- R4: A candidate replaces the current best only when it is strictly above the ratio and strictly below the best so far. The best starts at all ones. The search order is a outer and b inner, so of two equal divisors the earlier one is kept.
- R5: The code is packed as bits [4:2] = gb, bits [1:0] = ga[1:0], bit 5 = ga[2], and bits [7:6] = 0.
- R6: If no candidate qualifies, div_code = 0x31, divisor = 0 and actual_hz = req_hz.
- R7: When a candidate qualifies, divisor is that candidate and actual_hz = floor(src_hz / divisor).
- R8: A start seen while idle captures src_hz, req_hz and filt. busy is high from the next cycle until done. done is a one-cycle pulse, and the results are valid with it and hold until the next start.
- R9: start asserted while busy is high is ignored, and the running search finishes with the inputs it captured.
- R10: Reset, which is synchronous and active high, clears busy and done and sets div_code, divisor and actual_hz to zero. It also aborts a running search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a search (taken only while idle) |
| src_hz | input | 32 | Source clock frequency |
| req_hz | input | 32 | Requested bus speed |
| filt | input | 8 | Digital filter sampling value |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: results valid |
| div_code | output | 8 | Packed divider code |
| divisor | output | 32 | Chosen divisor, 0 when none qualified |
| actual_hz | output | 32 | Bus speed that results from the chosen divisor |

## Verification
The embedded properties rely on the divider holding its operands for the full 32 shift steps and on the ratio staying fixed while the grid is scanned. They also rely on the grid being cleared before the first candidate of every search. The bench changes inputs only on the falling edge and raises start only for single cycles, so each search captures one consistent set of operands. The one exception is a deliberate start raised in the middle of a search. The chosen speeds cover both ratios that land on a grid candidate and ratios that saturate or exceed the largest candidate of 61440, so the selection and the no-match paths both run.

// File: rtl/clkdiv_search_pkg.sv
package clkdiv_search_pkg;

    localparam int HZ_W         = 32;
    localparam int RATIO_W      = 16;
    localparam int RATIO_MAX    = (1 << RATIO_W) - 1;
    localparam int FILT_W       = 8;
    localparam int GA_W         = 4;
    localparam int A_W          = 6;
    localparam int GB_W         = 3;
    localparam int CODE_W       = 8;
    localparam int GA_FIRST     = 4;
    localparam int A_FIRST      = 10;
    localparam int A_STEP       = 2;
    localparam int A_JUMP_FROM  = 24;
    localparam int A_JUMP_EXTRA = 4;
    localparam int A_LAST       = 30;
    localparam int GB_LAST      = (1 << GB_W) - 1;
    localparam int B_SHIFT0     = 4;
    localparam logic [CODE_W-1:0] CODE_NONE = 8'h31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RATIO,
        ST_SCAN,
        ST_SETTLE,
        ST_SPEED,
        ST_FIN
    } eng_state_t;

    typedef struct packed {
        logic [GA_W-1:0] ga;
        logic [A_W-1:0]  a;
        logic [GB_W-1:0] gb;
    } grid_pt_t;

    // b * (a + 2 * floor(3*filt / b)) with b = 1 << (B_SHIFT0 + gb)
    function automatic logic [HZ_W-1:0] cand_div(input logic [A_W-1:0] a,
                                                 input logic [GB_W-1:0] gb,
                                                 input logic [FILT_W-1:0] filt);
        logic [HZ_W-1:0] trip;
        logic [HZ_W-1:0] sum;
        int sh;
        sh   = B_SHIFT0 + int'(gb);
        trip = HZ_W'(filt) * HZ_W'(3);
        sum  = HZ_W'(a) + ((trip >> sh) << 1);
        return sum << sh;
    endfunction

    function automatic logic [CODE_W-1:0] pack_code(input logic [GA_W-1:0] ga,
                                                    input logic [GB_W-1:0] gb);
        return {2'b00, ga[2], gb, ga[1:0]};
    endfunction

endpackage

// File: rtl/cds_divider.sv
module cds_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         valid,
    output logic [W-1:0] quot
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  den_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          valid_q;
    logic [W:0]    shifted;
    logic [W:0]    diff;
    logic          ge;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        ge      = shifted >= {1'b0, den_q};
        diff    = shifted - {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q   <= '0;
            quo_q   <= '0;
            den_q   <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (go && !busy_q) begin
                rem_q  <= '0;
                quo_q  <= num;
                den_q  <= den;
                cnt_q  <= CW'(W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= ge ? diff[W-1:0] : shifted[W-1:0];
                quo_q <= {quo_q[W-2:0], ge};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    busy_q  <= 1'b0;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign busy  = busy_q;
    assign valid = valid_q;
    assign quot  = quo_q;

    // R1: partial remainder stays below a nonzero divisor throughout
    assert_rem_below_den_R1: assert property (@(posedge clk) disable iff (rst)
        (busy_q && den_q != '0) |-> (rem_q < den_q));

    // R7: result pulse never overlaps a running division
    assert_valid_after_busy_R7: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> !busy_q);

endmodule

// File: rtl/cds_grid.sv
module cds_grid
    import clkdiv_search_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  logic     step,
    output grid_pt_t pt,
    output logic     last
);
    grid_pt_t pt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pt_q.ga <= GA_W'(GA_FIRST);
            pt_q.a  <= A_W'(A_FIRST);
            pt_q.gb <= '0;
        end else if (step) begin
            if (pt_q.gb == GB_W'(GB_LAST)) begin
                pt_q.gb <= '0;
                pt_q.ga <= pt_q.ga + GA_W'(1);
                if (pt_q.a == A_W'(A_JUMP_FROM))
                    pt_q.a <= pt_q.a + A_W'(A_STEP + A_JUMP_EXTRA);
                else
                    pt_q.a <= pt_q.a + A_W'(A_STEP);
            end else begin
                pt_q.gb <= pt_q.gb + GB_W'(1);
            end
        end
    end

    assign pt   = pt_q;
    assign last = (pt_q.a == A_W'(A_LAST)) && (pt_q.gb == GB_W'(GB_LAST));

    // R3: the row after a = 24 is a = 30
    assert_skip_row_R3: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && pt_q.gb == GB_W'(GB_LAST) && pt_q.a == A_W'(A_JUMP_FROM))
        |=> (pt_q.a == A_W'(A_LAST)));

    // R2: a stays on the even grid between first and last row
    assert_a_on_grid_R2: assert property (@(posedge clk) disable iff (rst)
        (pt_q.a[0] == 1'b0) && (pt_q.a >= A_W'(A_FIRST)) && (pt_q.a <= A_W'(A_LAST)));

endmodule

// File: rtl/cds_select.sv
module cds_select
    import clkdiv_search_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               en,
    input  logic [HZ_W-1:0]    cand,
    input  logic [RATIO_W-1:0] ratio,
    input  grid_pt_t           pt,
    output logic [HZ_W-1:0]    best_div,
    output logic [CODE_W-1:0]  best_code,
    output logic               hit
);
    logic [HZ_W-1:0]   best_q;
    logic [CODE_W-1:0] code_q;
    logic              hit_q;
    logic              accept;

    always_comb begin
        accept = en && (cand > HZ_W'(ratio)) && (cand < best_q);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            best_q <= '1;
            code_q <= CODE_NONE;
            hit_q  <= 1'b0;
        end else if (accept) begin
            best_q <= cand;
            code_q <= pack_code(pt.ga, pt.gb);
            hit_q  <= 1'b1;
        end
    end

    assign best_div  = best_q;
    assign best_code = code_q;
    assign hit       = hit_q;

    // R4: the kept divisor never grows within a search
    assert_best_nonincr_R4: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (best_q <= $past(best_q)));

    // R4: a kept divisor lies strictly above the ratio
    assert_best_above_ratio_R4: assert property (@(posedge clk) disable iff (rst)
        hit_q |-> (best_q > HZ_W'(ratio)));

endmodule

// File: rtl/clkdiv_search.sv
module clkdiv_search
    import clkdiv_search_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] src_hz,
    input  logic [31:0] req_hz,
    input  logic [7:0]  filt,
    output logic        busy,
    output logic        done,
    output logic [7:0]  div_code,
    output logic [31:0] divisor,
    output logic [31:0] actual_hz
);
    eng_state_t          st_q;
    logic [HZ_W-1:0]     src_q;
    logic [HZ_W-1:0]     req_q;
    logic [FILT_W-1:0]   filt_q;
    logic [RATIO_W-1:0]  ratio_q;
    logic [CODE_W-1:0]   code_q;
    logic [HZ_W-1:0]     divisor_q;
    logic [HZ_W-1:0]     actual_q;

    logic                dv_go;
    logic [HZ_W-1:0]     dv_num;
    logic [HZ_W-1:0]     dv_den;
    logic                dv_busy;
    logic                dv_valid;
    logic [HZ_W-1:0]     dv_quot;

    grid_pt_t            pt;
    logic                grid_last;
    logic                grid_clear;
    logic                grid_step;
    logic [HZ_W-1:0]     cand;
    logic [HZ_W-1:0]     sel_div;
    logic [CODE_W-1:0]   sel_code;
    logic                sel_hit;
    logic                launch;

    always_comb begin
        launch     = (st_q == ST_IDLE) && start;
        dv_go      = launch || ((st_q == ST_SETTLE) && sel_hit);
        dv_num     = (st_q == ST_IDLE) ? src_hz : src_q;
        dv_den     = (st_q == ST_IDLE) ? req_hz : sel_div;
        grid_clear = launch;
        grid_step  = (st_q == ST_SCAN) && !grid_last;
        cand       = cand_div(pt.a, pt.gb, filt_q);
    end

    cds_divider #(.W(HZ_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .go    (dv_go),
        .num   (dv_num),
        .den   (dv_den),
        .busy  (dv_busy),
        .valid (dv_valid),
        .quot  (dv_quot)
    );

    cds_grid u_grid (
        .clk   (clk),
        .rst   (rst),
        .clear (grid_clear),
        .step  (grid_step),
        .pt    (pt),
        .last  (grid_last)
    );

    cds_select u_sel (
        .clk       (clk),
        .rst       (rst),
        .clear     (grid_clear),
        .en        (st_q == ST_SCAN),
        .cand      (cand),
        .ratio     (ratio_q),
        .pt        (pt),
        .best_div  (sel_div),
        .best_code (sel_code),
        .hit       (sel_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            src_q     <= '0;
            req_q     <= '0;
            filt_q    <= '0;
            ratio_q   <= '0;
            code_q    <= '0;
            divisor_q <= '0;
            actual_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        src_q  <= src_hz;
                        req_q  <= req_hz;
                        filt_q <= filt;
                        st_q   <= ST_RATIO;
                    end
                end
                ST_RATIO: begin
                    if (dv_valid) begin
                        ratio_q <= (dv_quot > HZ_W'(RATIO_MAX)) ? RATIO_W'(RATIO_MAX)
                                                                : dv_quot[RATIO_W-1:0];
                        st_q    <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (grid_last) st_q <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    code_q <= sel_code;
                    if (sel_hit) begin
                        divisor_q <= sel_div;
                        st_q      <= ST_SPEED;
                    end else begin
                        divisor_q <= '0;
                        actual_q  <= req_q;
                        st_q      <= ST_FIN;
                    end
                end
                ST_SPEED: begin
                    if (dv_valid) begin
                        actual_q <= dv_quot;
                        st_q     <= ST_FIN;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (st_q != ST_IDLE);
    assign done      = (st_q == ST_FIN);
    assign div_code  = code_q;
    assign divisor   = divisor_q;
    assign actual_hz = actual_q;

    // R8: done lasts a single cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: operands captured at launch do not move while busy
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(src_q) && $stable(req_q) && $stable(filt_q)));

    // R6: an empty result carries the fallback code and the requested speed
    assert_no_match_default_R6: assert property (@(posedge clk) disable iff (rst)
        (done && divisor_q == '0) |-> (code_q == CODE_NONE && actual_q == req_q));

    // R4: a reported divisor lies above the ratio it was chosen for
    assert_result_above_ratio_R4: assert property (@(posedge clk) disable iff (rst)
        (done && divisor_q != '0) |-> (divisor_q > HZ_W'(ratio_q)));

    // R7: the shared divider is idle whenever results are presented
    assert_div_idle_at_done_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !dv_busy);

endmodule

// File: tb/sim_clkdiv_search.sv
module sim_clkdiv_search;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 8;
    localparam int RUN_LIMIT  = 1000;

    // stimulus: source, request, filter; expected: code, divisor, speed
    localparam logic [31:0] V_SRC  [N_VEC] = '{32'd100000000, 32'd100000000, 32'd383,
                                               32'd44800000, 32'd61439, 32'hFFFFFFFF,
                                               32'd5000, 32'd100};
    localparam logic [31:0] V_REQ  [N_VEC] = '{32'd400000, 32'd400000, 32'd1, 32'd100000,
                                               32'd1, 32'd1, 32'd0, 32'd1};
    localparam logic [7:0]  V_FILT [N_VEC] = '{8'd0, 8'd16, 8'd0, 8'd0, 8'd0, 8'd0,
                                               8'd0, 8'd0};
    localparam logic [7:0]  V_CODE [N_VEC] = '{8'h23, 8'h20, 8'h25, 8'h20, 8'h3C, 8'h31,
                                               8'h31, 8'h20};
    localparam logic [31:0] V_DIV  [N_VEC] = '{32'd256, 32'd256, 32'd384, 32'd480,
                                               32'd61440, 32'd0, 32'd0, 32'd160};
    localparam logic [31:0] V_ACT  [N_VEC] = '{32'd390625, 32'd390625, 32'd0, 32'd93333,
                                               32'd0, 32'd1, 32'd0, 32'd0};

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] src_hz;
    logic [31:0] req_hz;
    logic [7:0]  filt;
    logic        busy;
    logic        done;
    logic [7:0]  div_code;
    logic [31:0] divisor;
    logic [31:0] actual_hz;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    clkdiv_search u0 (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .src_hz    (src_hz),
        .req_hz    (req_hz),
        .filt      (filt),
        .busy      (busy),
        .done      (done),
        .div_code  (div_code),
        .divisor   (divisor),
        .actual_hz (actual_hz)
    );

    function automatic string tag_of(input int i);
        case (i)
            0: return "R1 R5 R7 plain ratio";
            1: return "R2 filter term";
            2: return "R4 tie keeps earliest";
            3: return "R3 row a=30 reached";
            4: return "R5 last candidate";
            5: return "R6 R1 saturated ratio";
            6: return "R1 R6 zero request";
            default: return "R7 small ratio";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic launch(input logic [31:0] s, input logic [31:0] r, input logic [7:0] f);
        @(negedge clk);
        src_hz = s;
        req_hz = r;
        filt   = f;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        chk("R8 busy after start", {31'd0, busy}, 32'd1);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < RUN_LIMIT) begin
            @(negedge clk);
            n++;
        end
        if (!done) chk("R8 watchdog on done", 32'd0, 32'd1);
    endtask

    task automatic check_result(input string tag, input int i);
        chk({tag, " code"},    {24'd0, div_code}, {24'd0, V_CODE[i]});
        chk({tag, " divisor"}, divisor,   V_DIV[i]);
        chk({tag, " speed"},   actual_hz, V_ACT[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R8 global watchdog expired got 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst    = 1'b1;
        start  = 1'b0;
        src_hz = '0;
        req_hz = '0;
        filt   = '0;
        repeat (3) @(negedge clk);
        // R10: state after reset
        chk("R10 busy", {31'd0, busy}, 32'd0);
        chk("R10 done", {31'd0, done}, 32'd0);
        chk("R10 code", {24'd0, div_code}, 32'd0);
        chk("R10 divisor", divisor, 32'd0);
        chk("R10 speed", actual_hz, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < N_VEC; i++) begin
            launch(V_SRC[i], V_REQ[i], V_FILT[i]);
            wait_done();
            check_result(tag_of(i), i);
            @(negedge clk);
            // R8: pulse ends, results held
            chk("R8 done single cycle", {31'd0, done}, 32'd0);
            chk("R8 code held", {24'd0, div_code}, {24'd0, V_CODE[i]});
            chk("R8 busy cleared", {31'd0, busy}, 32'd0);
        end

        // R9: a second start mid-search is ignored
        launch(V_SRC[0], V_REQ[0], V_FILT[0]);
        repeat (5) @(negedge clk);
        src_hz = V_SRC[5];
        req_hz = V_REQ[5];
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        src_hz = '0;
        wait_done();
        check_result("R9 start while busy", 0);

        // R10: reset aborts a running search and clears outputs
        launch(V_SRC[3], V_REQ[3], V_FILT[3]);
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 abort busy", {31'd0, busy}, 32'd0);
        chk("R10 abort code", {24'd0, div_code}, 32'd0);
        chk("R10 abort divisor", divisor, 32'd0);

        // engine usable again after the abort
        launch(V_SRC[4], V_REQ[4], V_FILT[4]);
        wait_done();
        check_result("R5 after abort", 4);

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule